// File: doc/BRIEF.md
# Paged Stack Pointer with Context Frame Sequencer

This block keeps a byte stack inside a fixed 64-byte page and moves CPU context frames between the processor registers and a byte-wide memory port. Only six bits of the pointer are real. The upper seven bits of the 13-bit address are tied to 0000011, so every stack access falls between 0x0C0 and 0x0FF. When the stack overflows, the pointer wraps inside the page and overwrites old entries without any warning.

A call request saves a two-byte return address. An interrupt request saves a five-byte frame that holds the program counter, the index register, the accumulator and the five condition-code bits. The matching return and return-from-interrupt requests read the same bytes back in reverse order and load the restored-value outputs. One byte moves per clock. A one-cycle `done` pulse marks the end of each sequence. A stack-reset command sets the pointer back to the top of the page.

Top module: `stack_frame_unit`

## Requirements
- R1: After reset the idle stack address is 0x0FF (offset 63), `mem_we` and `done` are low, and `pc_out`, `x_out`, `a_out` and `ccr_out` are zero.
- R2: A `sp_rst` sampled in an idle cycle makes the idle address 0x0FF from the next cycle on.
- R3: Bits 12..6 of every stack address are 0000011. A push below 0x0C0 wraps to 0x0FF and a pull above 0x0FF wraps to 0x0C0, with no error indication.
- R4: A push request sampled while idle is accepted at that edge, and the operand inputs are captured there. From the next cycle on, one byte per cycle is written at the current address, and the pointer then moves down by one.
- R5: A call frame is written as PC[7:0] first, then {3'b000, PC[12:8]}.
- R6: An interrupt frame is written as PC[7:0], {3'b000, PC[12:8]}, X, A and then {3'b111, CCR[4:0]}, in that order.
- R7: On every pull the pointer first moves up by one and the byte at the new address is read. A return reads the PC high byte and then the low byte, and updates only `pc_out`. The top three bits of the high byte are ignored.
- R8: A return-from-interrupt reads the CCR, A, X, PC high and PC low bytes in that order and updates all four restored outputs. The top three bits of the CCR byte are ignored.
- R9: `done` is high for exactly one cycle, the cycle right after the last byte transfer, and `mem_we` is low in that cycle.
- R10: Requests sampled in the same cycle are served in this order: stack reset, interrupt, call, return-from-interrupt, return. Any request sampled while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_rst | input | 1 | Stack-reset command |
| call_req | input | 1 | Save a two-byte return address |
| irq_req | input | 1 | Save a five-byte interrupt frame |
| ret_req | input | 1 | Restore a two-byte return address |
| rti_req | input | 1 | Restore a five-byte interrupt frame |
| pc_in | input | 13 | Program counter to save |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| ccr_in | input | 5 | Condition codes to save |
| mem_rdata | input | 8 | Read data for the current address (combinational) |
| mem_addr | output | 13 | Stack memory address |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| pc_out | output | 13 | Restored program counter |
| x_out | output | 8 | Restored index register |
| a_out | output | 8 | Restored accumulator |
| ccr_out | output | 5 | Restored condition codes |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Every one of the 32 condition-code values goes through an interrupt frame and its return, with PC, X and A derived arithmetically from that value. This separates a lost or misplaced frame byte from a padding error in the CCR byte. Call and return pairs use PC values with all-zero and all-one high and low halves, and a nested call inside an interrupt shows that a return touches only the PC. Fourteen back-to-back interrupt frames drive the pointer past the page bottom, and a return issued straight after a stack reset drives it past the top, which exposes any carry into the fixed upper address bits. Corrupted padding bits in memory, simultaneous requests, and requests held high while a push runs show that the ignore rules and the priority order are kept.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_CALL, OP_IRQ, OP_RET, OP_RTI} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_PULL} st_e;
  typedef enum logic [2:0] {SL_PCL, SL_PCH, SL_X, SL_A, SL_CCR} slot_e;

  localparam int IDX_W = 3;

  // Bytes moved by an operation.
  function automatic logic [IDX_W-1:0] frame_len(op_e op);
    case (op)
      OP_IRQ, OP_RTI:  return 3'd5;
      OP_CALL, OP_RET: return 3'd2;
      default:         return 3'd1;
    endcase
  endfunction

  // Push order; a call frame is the first two entries of an interrupt frame.
  function automatic slot_e slot_at(logic [IDX_W-1:0] k);
    case (k)
      3'd0:    return SL_PCL;
      3'd1:    return SL_PCH;
      3'd2:    return SL_X;
      3'd3:    return SL_A;
      default: return SL_CCR;
    endcase
  endfunction

  function automatic logic is_push(op_e op);
    return (op == OP_CALL) || (op == OP_IRQ);
  endfunction

  // Priority among requests sampled in the same cycle.
  function automatic op_e pick_op(logic call_r, logic irq_r, logic ret_r, logic rti_r);
    if (irq_r)       return OP_IRQ;
    else if (call_r) return OP_CALL;
    else if (rti_r)  return OP_RTI;
    else if (ret_r)  return OP_RET;
    else             return OP_NONE;
  endfunction
endpackage

// File: rtl/stk_pointer.sv
module stk_pointer #(
  parameter int ADDR_W = 13,
  parameter int OFS_W  = 6,
  parameter logic [ADDR_W-OFS_W-1:0] PAGE_HI = 7'b0000011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_top,
  input  logic              step_dn,
  input  logic              step_up,
  output logic [ADDR_W-1:0] addr_cur,
  output logic [ADDR_W-1:0] addr_pull
);
  logic [OFS_W-1:0] ofs_q;
  logic [OFS_W-1:0] ofs_inc;

  // Offset arithmetic stays in OFS_W bits, so it wraps inside the page.
  function automatic logic [OFS_W-1:0] wrap_step(logic [OFS_W-1:0] v, logic up);
    return up ? v + 1'b1 : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        ofs_q <= {OFS_W{1'b1}};
    else if (load_top) ofs_q <= {OFS_W{1'b1}};
    else if (step_dn)  ofs_q <= wrap_step(ofs_q, 1'b0);
    else if (step_up)  ofs_q <= wrap_step(ofs_q, 1'b1);
  end

  assign ofs_inc   = wrap_step(ofs_q, 1'b1);
  assign addr_cur  = {PAGE_HI, ofs_q};
  assign addr_pull = {PAGE_HI, ofs_inc};

  // R2
  top_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_top |=> ofs_q == {OFS_W{1'b1}});
  // R4
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !load_top) |=> ofs_q == OFS_W'($past(ofs_q) - 1'b1));
  // R7
  pull_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !load_top && !step_dn) |=> ofs_q == OFS_W'($past(ofs_q) + 1'b1));
endmodule

// File: rtl/stk_byte_path.sv
module stk_byte_path import stk_pkg::*; #(
  parameter int PC_W   = 13,
  parameter int CCR_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0] x_in,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [CCR_W-1:0]  ccr_in,
  input  slot_e             slot,
  output logic [BYTE_W-1:0] wdata
);
  localparam int PCH_W   = PC_W - BYTE_W;
  localparam int PCH_PAD = BYTE_W - PCH_W;
  localparam int CCR_PAD = BYTE_W - CCR_W;

  logic [PC_W-1:0]   pc_l;
  logic [BYTE_W-1:0] x_l, a_l;
  logic [CCR_W-1:0]  ccr_l;

  function automatic logic [BYTE_W-1:0] pack_pch(logic [PC_W-1:0] pc);
    return {{PCH_PAD{1'b0}}, pc[PC_W-1:BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] pack_ccr(logic [CCR_W-1:0] c);
    return {{CCR_PAD{1'b1}}, c};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_l <= '0; x_l <= '0; a_l <= '0; ccr_l <= '0;
    end else if (latch_en) begin
      pc_l <= pc_in; x_l <= x_in; a_l <= a_in; ccr_l <= ccr_in;
    end
  end

  always_comb begin
    case (slot)
      SL_PCL:  wdata = pc_l[BYTE_W-1:0];
      SL_PCH:  wdata = pack_pch(pc_l);
      SL_X:    wdata = x_l;
      SL_A:    wdata = a_l;
      default: wdata = pack_ccr(ccr_l);
    endcase
  end
endmodule

// File: rtl/stk_restore.sv
module stk_restore import stk_pkg::*; #(
  parameter int PC_W   = 13,
  parameter int CCR_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  slot_e             slot,
  input  logic [BYTE_W-1:0] rdata,
  output logic [PC_W-1:0]   pc_out,
  output logic [BYTE_W-1:0] x_out,
  output logic [BYTE_W-1:0] a_out,
  output logic [CCR_W-1:0]  ccr_out
);
  localparam int PCH_W = PC_W - BYTE_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_out <= '0; x_out <= '0; a_out <= '0; ccr_out <= '0;
    end else if (cap_en) begin
      case (slot)
        SL_PCL:  pc_out[BYTE_W-1:0]    <= rdata;
        SL_PCH:  pc_out[PC_W-1:BYTE_W] <= rdata[PCH_W-1:0];
        SL_X:    x_out                 <= rdata;
        SL_A:    a_out                 <= rdata;
        default: ccr_out               <= rdata[CCR_W-1:0];
      endcase
    end
  end

  // R8
  ccr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && slot == SL_CCR) |=> ccr_out == $past(rdata[CCR_W-1:0]));
  // R7
  pch_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && slot == SL_PCH) |=> pc_out[PC_W-1:BYTE_W] == $past(rdata[PCH_W-1:0]));
  // R7
  x_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_en && slot == SL_X) |=> $stable(x_out));
endmodule

// File: rtl/stk_seq.sv
module stk_seq import stk_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sp_rst,
  input  logic  call_req,
  input  logic  irq_req,
  input  logic  ret_req,
  input  logic  rti_req,
  output logic  load_top,
  output logic  step_dn,
  output logic  step_up,
  output logic  latch_en,
  output logic  cap_en,
  output slot_e slot,
  output logic  done
);
  st_e              st_q;
  op_e              op_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  op_e              req_op;
  logic             idle, accept, last;

  assign req_op = pick_op(call_req, irq_req, ret_req, rti_req);
  assign idle   = (st_q == ST_IDLE);
  assign accept = idle && !sp_rst && (req_op != OP_NONE);
  assign last   = (idx_q == IDX_W'(frame_len(op_q) - 3'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; op_q <= OP_NONE; idx_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          op_q  <= req_op;
          idx_q <= '0;
          st_q  <= is_push(req_op) ? ST_PUSH : ST_PULL;
        end
        default: if (last) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign load_top = idle && sp_rst;
  assign latch_en = accept && is_push(req_op);
  assign step_dn  = (st_q == ST_PUSH);
  assign step_up  = (st_q == ST_PULL);
  assign cap_en   = step_up;
  assign slot     = step_up ? slot_at(IDX_W'(frame_len(op_q) - 3'd1 - idx_q))
                            : slot_at(idx_q);
  assign done     = done_q;

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && last) |=> done_q && st_q == ST_IDLE);
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !last) |=> st_q == $past(st_q) && op_q == $past(op_q));
endmodule

// File: rtl/stack_frame_unit.sv
module stack_frame_unit import stk_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int OFS_W  = 6,
  parameter logic [ADDR_W-OFS_W-1:0] PAGE_HI = 7'b0000011,
  parameter int PC_W   = 13,
  parameter int CCR_W  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp_rst,
  input  logic              call_req,
  input  logic              irq_req,
  input  logic              ret_req,
  input  logic              rti_req,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0] x_in,
  input  logic [BYTE_W-1:0] a_in,
  input  logic [CCR_W-1:0]  ccr_in,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [PC_W-1:0]   pc_out,
  output logic [BYTE_W-1:0] x_out,
  output logic [BYTE_W-1:0] a_out,
  output logic [CCR_W-1:0]  ccr_out,
  output logic              done
);
  logic              load_top, step_dn, step_up, latch_en, cap_en;
  slot_e             slot;
  logic [ADDR_W-1:0] addr_cur, addr_pull;

  stk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sp_rst(sp_rst),
    .call_req(call_req), .irq_req(irq_req), .ret_req(ret_req), .rti_req(rti_req),
    .load_top(load_top), .step_dn(step_dn), .step_up(step_up),
    .latch_en(latch_en), .cap_en(cap_en), .slot(slot), .done(done)
  );

  stk_pointer #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PAGE_HI(PAGE_HI)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_top(load_top), .step_dn(step_dn),
    .step_up(step_up), .addr_cur(addr_cur), .addr_pull(addr_pull)
  );

  stk_byte_path #(.PC_W(PC_W), .CCR_W(CCR_W), .BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .pc_in(pc_in), .x_in(x_in),
    .a_in(a_in), .ccr_in(ccr_in), .slot(slot), .wdata(mem_wdata)
  );

  stk_restore #(.PC_W(PC_W), .CCR_W(CCR_W), .BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .slot(slot), .rdata(mem_rdata),
    .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .ccr_out(ccr_out)
  );

  assign mem_we   = step_dn;
  assign mem_addr = step_up ? addr_pull : addr_cur;

  // R9
  we_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);
  // R3
  page_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || step_up) |-> mem_addr[ADDR_W-1:OFS_W] == PAGE_HI);
endmodule

// File: tb/tb_stack_frame_unit.sv
module tb_stack_frame_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sp_rst = 1'b0, call_req = 1'b0, irq_req = 1'b0, ret_req = 1'b0, rti_req = 1'b0;
  logic [12:0] pc_in = '0;
  logic [7:0]  x_in = '0, a_in = '0;
  logic [4:0]  ccr_in = '0;
  logic [7:0]  mem_rdata, mem_wdata, x_out, a_out;
  logic [12:0] mem_addr, pc_out;
  logic [4:0]  ccr_out;
  logic        mem_we, done;

  logic [7:0] mem [0:63];
  int nchk = 0, nerr = 0, msp = 63;
  int cur_x = 0, cur_a = 0, cur_ccr = 0;

  always #5 clk = ~clk;
  assign mem_rdata = mem[mem_addr[5:0]];

  stack_frame_unit dut (
    .clk(clk), .rst_n(rst_n), .sp_rst(sp_rst), .call_req(call_req), .irq_req(irq_req),
    .ret_req(ret_req), .rti_req(rti_req), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
    .ccr_in(ccr_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .ccr_out(ccr_out),
    .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Push a frame; the bench acts as the memory and checks every byte.
  task automatic do_push(input bit irq, input int pc, input int x, input int a,
                         input int ccr, input bit noise, input bit both);
    int exp [5];
    int n;
    exp[0] = pc % 256; exp[1] = pc / 256; exp[2] = x; exp[3] = a; exp[4] = 224 + ccr;
    n = irq ? 5 : 2;
    @(negedge clk);
    pc_in = 13'(pc); x_in = 8'(x); a_in = 8'(a); ccr_in = 5'(ccr);
    irq_req = irq; call_req = !irq || both;
    @(negedge clk);
    irq_req = 0; call_req = 0;
    pc_in = ~pc_in; x_in = ~x_in; a_in = ~a_in; ccr_in = ~ccr_in; // R4 capture
    for (int k = 0; k < n; k++) begin
      if (noise) begin ret_req = 1; call_req = 1; end // R10 ignored while busy
      chk("R4 we", mem_we, 1);
      chk("R3 push addr", mem_addr, 'h0C0 + msp);
      chk((k < 2 && !irq) ? "R5 byte" : "R6 byte", mem_wdata, exp[k]);
      mem[msp] = mem_wdata;
      msp = (msp + 63) % 64;
      @(negedge clk);
    end
    ret_req = 0; call_req = 0;
    chk("R9 done", done, 1);
    chk("R9 we low", mem_we, 0);
    chk("R4 idle addr", mem_addr, 'h0C0 + msp);
    @(negedge clk);
    chk("R9 done drop", done, 0);
    chk("R10 no extra", mem_we, 0);
  endtask

  task automatic do_pull(input bit irq, input int epc, input int ex, input int ea, input int eccr);
    int n;
    n = irq ? 5 : 2;
    @(negedge clk);
    rti_req = irq; ret_req = !irq;
    @(negedge clk);
    rti_req = 0; ret_req = 0;
    for (int j = 0; j < n; j++) begin
      chk("R7 no write", mem_we, 0);
      chk("R3 pull addr", mem_addr, 'h0C0 + (msp + 1) % 64);
      msp = (msp + 1) % 64;
      @(negedge clk);
    end
    chk("R9 done", done, 1);
    chk(irq ? "R8 pc" : "R7 pc", pc_out, epc);
    chk(irq ? "R8 x" : "R7 x kept", x_out, ex);
    chk(irq ? "R8 a" : "R7 a kept", a_out, ea);
    chk(irq ? "R8 ccr" : "R7 ccr kept", ccr_out, eccr);
    cur_x = ex; cur_a = ea; cur_ccr = eccr;
    @(negedge clk);
    chk("R9 done drop", done, 0);
  endtask

  task automatic do_sprst(input bit with_call);
    @(negedge clk);
    sp_rst = 1; call_req = with_call;
    @(negedge clk);
    sp_rst = 0; call_req = 0;
    msp = 63;
    chk("R2 top addr", mem_addr, 'h0FF);
    chk("R10 reset wins", mem_we, 0);
  endtask

  initial begin
    #2000000;
    nchk++; nerr++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int epc;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 addr", mem_addr, 'h0FF);
    chk("R1 we", mem_we, 0);
    chk("R1 done", done, 0);
    chk("R1 pc", pc_out, 0);
    chk("R1 x", x_out, 0);
    chk("R1 a", a_out, 0);
    chk("R1 ccr", ccr_out, 0);

    // R6 R8: every CCR value through a frame and its return
    for (int c = 0; c < 32; c++) begin
      do_push(1, (c * 257 + 13) % 8192, c * 7, 255 - c * 3, c, 0, 0);
      do_pull(1, (c * 257 + 13) % 8192, c * 7, 255 - c * 3, c);
    end

    // R5 R7: call/return edge values of PC
    foreach (epc_list[i]) begin
      do_push(0, epc_list[i], 0, 0, 0, 0, 0);
      do_pull(0, epc_list[i], cur_x, cur_a, cur_ccr);
    end

    // Nested call inside an interrupt
    do_push(0, 'h0100, 0, 0, 0, 0, 0);
    do_push(1, 'h1ABC, 'h5A, 'hA5, 'h13, 0, 0);
    do_pull(1, 'h1ABC, 'h5A, 'hA5, 'h13);
    do_pull(0, 'h0100, 'h5A, 'hA5, 'h13);

    // R7 R8: padding bits in memory are ignored on restore
    do_push(1, 'h0ABC, 'h11, 'h22, 'h15, 0, 0);
    mem[(msp + 1) % 64] = mem[(msp + 1) % 64] & 8'h1F;
    mem[(msp + 4) % 64] = mem[(msp + 4) % 64] | 8'hE0;
    do_pull(1, 'h0ABC, 'h11, 'h22, 'h15);

    // R10: interrupt beats call; requests held during a push are ignored
    do_push(1, 'h0777, 'h01, 'h02, 'h03, 0, 1);
    do_pull(1, 'h0777, 'h01, 'h02, 'h03);
    do_push(1, 'h1555, 'h44, 'h55, 'h0A, 1, 0);
    do_pull(1, 'h1555, 'h44, 'h55, 'h0A);

    // R3: 70 bytes wrap past the page bottom; newest frames still intact
    for (int i = 0; i < 14; i++) do_push(1, i * 300 + 7, i, i + 100, i % 32, 0, 0);
    do_pull(1, 13 * 300 + 7, 13, 113, 13);
    do_pull(1, 12 * 300 + 7, 12, 112, 12);

    // R2 R10: stack reset beats a call, then a return wraps past the top
    do_sprst(1);
    epc = (mem[0] % 32) * 256 + mem[1];
    do_pull(0, epc, cur_x, cur_a, cur_ccr);
    chk("R3 wrapped addr", mem_addr, 'h0C1);
    do_sprst(0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  int epc_list [5] = '{0, 'h1FFF, 'h1234, 'h00FF, 'h1F00};
endmodule